// File: doc/BRIEF.md
# Adaptive Pushbutton Contact Debouncer

This block turns one active-low pushbutton line into clean events for downstream logic. Mechanical contacts chatter when they close. The block therefore times each low stretch of the line against a free-running tick from an internal timebase, and it restarts that measurement whenever the line bounces back high. A closure counts as a press only when the low level holds, unbroken, for a full plateau of `ACCEPT_TICKS` ticks. Every shorter low stretch is thrown away, whether it is a brief chatter spike or a longer dip of 7 to 10 ticks.

When a press is accepted, the block raises a one-cycle strobe and sets a held flag. The flag stays set until the line returns high. After that, the line must stay high for `MIN_HIGH_CYCLES` consecutive clock cycles before the block re-arms. A shorter high gap is treated as release chatter. It puts the block back into the held condition and issues no new strobe.

The controller has four states:

- `ST_IDLE`: waiting for the line to go low.
- `ST_LOW_TIMING`: timing a low plateau.
- `ST_HELD`: the press has been accepted.
- `ST_RELEASE`: measuring the high gap after release.

The state transitions are:

- `IDLE->LOW_TIMING` on a low level.
- `LOW_TIMING->IDLE` on any high level before acceptance (bounce reject).
- `LOW_TIMING->HELD` when the plateau completes (accept, strobe).
- `HELD->RELEASE` on a high level.
- `RELEASE->HELD` on a low level before the gap completes (release chatter).
- `RELEASE->IDLE` when the gap completes (re-arm).

Top module: `btn_settle`

## Requirements
- R1: The input `btn_n_i` is active low: 0 means pressed and 1 means idle. It passes through `SYNC_STAGES` synchronizer flops, which reset to 1. A line that stays at 1 never produces a strobe.
- R2: If the synchronized line returns to 1 before `ACCEPT_TICKS` ticks have been counted in `ST_LOW_TIMING`, the block returns to `ST_IDLE`, clears the timer and issues no strobe. This applies both to short chatter and to lows of 7 to 10 ticks when `ACCEPT_TICKS` is 11.
- R3: A low plateau that reaches `ACCEPT_TICKS` ticks produces exactly one `press_o` pulse, one clock wide. `held_o` rises in the same cycle as the pulse.
- R4: A tick occurs every `CYCLES_PER_TICK` clocks. The strobe appears no earlier than (`ACCEPT_TICKS`-1)·`CYCLES_PER_TICK` and no later than `ACCEPT_TICKS`·`CYCLES_PER_TICK`+`SYNC_STAGES`+4 clock cycles after the pin falls.
- R5: While the line stays low after acceptance, `held_o` stays 1 and no second strobe is issued.
- R6: `held_o` drops within `SYNC_STAGES`+2 cycles of the pin returning to 1. If the line goes low again before it has been high for `MIN_HIGH_CYCLES` cycles, the block returns to `ST_HELD` (`held_o`=1) without a strobe.
- R7: Presses of at least `ACCEPT_TICKS`+1 ticks, separated by high gaps of at least `MIN_HIGH_CYCLES`+`SYNC_STAGES`+2 cycles, each yield exactly one strobe.
- R8: Reset (`rst_i`=1, synchronous) forces `ST_IDLE`, clears both counters and drives `press_o`=0 and `held_o`=0, even in the middle of a press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| btn_n_i | input | 1 | Raw pushbutton line, active low |
| press_o | output | 1 | One-cycle accepted-press strobe |
| held_o | output | 1 | Button-held level flag |

## Verification
The bench builds the block with `CYCLES_PER_TICK`=8, `ACCEPT_TICKS`=11, `MIN_HIGH_CYCLES`=6 and `SYNC_STAGES`=2. A full 11-tick plateau then takes under a hundred clocks. This keeps within a short run the chatter trains, the 9-tick rejected lows, long holds of 40 ticks, short and long release gaps, back-to-back presses and the latency window. The latency window is measured against the free-running tick phase. The small gap parameter lets the bench place release chatter just inside and just outside the re-arm rule, cycle by cycle.

// File: rtl/btn_settle_pkg.sv
package btn_settle_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_LOW_TIMING = 2'd1,
        ST_HELD       = 2'd2,
        ST_RELEASE    = 2'd3
    } settle_state_t;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign q_o = d_i;
        end else begin : g_chain
            logic [STAGES-1:0] chain_q;
            always_ff @(posedge clk_i) begin
                if (rst_i) chain_q <= '1;
                else       chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], d_i} ;
            end
            assign q_o = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/btn_tick_gen.sv
module btn_tick_gen #(
    parameter int CYCLES_PER_TICK = 50000
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    localparam int CW = (CYCLES_PER_TICK > 1) ? $clog2(CYCLES_PER_TICK) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES_PER_TICK - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk_i) begin
        if (rst_i)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == LAST);
endmodule

// File: rtl/btn_span_counter.sv
module btn_span_counter #(
    parameter int LIMIT = 11
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic run_i,
    input  logic step_i,
    output logic done_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || !run_i)              cnt_q <= '0;
        else if (step_i && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == TOP);

    // R4: the span measurement saturates at its limit and never wraps
    assert_span_saturates_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (cnt_q == TOP && run_i) |=> (cnt_q == TOP || !$past(run_i) || cnt_q == '0));
    // R2: dropping out of the measured state clears the count
    assert_span_clears_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/btn_settle.sv
module btn_settle
    import btn_settle_pkg::*;
#(
    parameter int CYCLES_PER_TICK = 50000,
    parameter int ACCEPT_TICKS    = 11,
    parameter int MIN_HIGH_CYCLES = 50,
    parameter int SYNC_STAGES     = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic btn_n_i,
    output logic press_o,
    output logic held_o
);
    logic          lvl_n;
    logic          tick;
    logic          low_done;
    logic          high_done;
    settle_state_t state_q, state_d;
    logic          press_q, held_q;

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i(clk_i), .rst_i(rst_i), .d_i(btn_n_i), .q_o(lvl_n)
    );

    btn_tick_gen #(.CYCLES_PER_TICK(CYCLES_PER_TICK)) u_tick (
        .clk_i(clk_i), .rst_i(rst_i), .tick_o(tick)
    );

    btn_span_counter #(.LIMIT(ACCEPT_TICKS)) u_low_timer (
        .clk_i(clk_i), .rst_i(rst_i),
        .run_i(state_q == ST_LOW_TIMING), .step_i(tick), .done_o(low_done)
    );

    btn_span_counter #(.LIMIT(MIN_HIGH_CYCLES)) u_gap_timer (
        .clk_i(clk_i), .rst_i(rst_i),
        .run_i(state_q == ST_RELEASE), .step_i(1'b1), .done_o(high_done)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (!lvl_n) state_d = ST_LOW_TIMING;
            ST_LOW_TIMING: begin
                if (lvl_n)         state_d = ST_IDLE;
                else if (low_done) state_d = ST_HELD;
            end
            ST_HELD:       if (lvl_n) state_d = ST_RELEASE;
            ST_RELEASE: begin
                if (!lvl_n)         state_d = ST_HELD;
                else if (high_done) state_d = ST_IDLE;
            end
            default:       state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_IDLE;
        else       state_q <= state_d;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            press_q <= 1'b0;
            held_q  <= 1'b0;
        end else begin
            press_q <= (state_q == ST_LOW_TIMING) && (state_d == ST_HELD);
            held_q  <= (state_d == ST_HELD);
        end
    end

    assign press_o = press_q;
    assign held_o  = held_q;

    // R3: an accepted press always comes with the held flag
    assert_strobe_with_held_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        press_o |-> held_o);
    // R5: the strobe is a single cycle wide
    assert_single_strobe_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        press_o |=> !press_o);
    // R2: a high level during timing never leads to acceptance
    assert_bounce_rejected_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_LOW_TIMING && lvl_n) |=> (!press_o && !held_o));
    // R6: the held flag drops once the synchronized line is high
    assert_held_drops_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (held_o && lvl_n && state_q == ST_HELD) |=> !held_o);
    // R1: an idle line keeps the block out of timing
    assert_idle_stays_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_IDLE && lvl_n) |=> (state_q == ST_IDLE));
endmodule

// File: tb/btn_settle_bench.sv
module btn_settle_bench;
    localparam int CPT = 8;
    localparam int ACC = 11;
    localparam int MINH = 6;
    localparam int SYN = 2;
    localparam int GAP_OK = MINH + SYN + 4;

    logic clk = 1'b0;
    logic rst;
    logic btn_n;
    logic press, held;

    int vectors = 0;
    int errors = 0;
    int strobes = 0;
    int cyc = 0;
    int first_strobe_cyc = -1;

    always #10 clk = ~clk;

    btn_settle #(
        .CYCLES_PER_TICK(CPT), .ACCEPT_TICKS(ACC),
        .MIN_HIGH_CYCLES(MINH), .SYNC_STAGES(SYN)
    ) u_btn_settle (
        .clk_i(clk), .rst_i(rst), .btn_n_i(btn_n), .press_o(press), .held_o(held)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (press) begin
            strobes <= strobes + 1;
            if (first_strobe_cyc < 0) first_strobe_cyc <= cyc;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic low_for(input int n);
        btn_n = 1'b0; wait_cycles(n);
    endtask

    task automatic high_for(input int n);
        btn_n = 1'b1; wait_cycles(n);
    endtask

    task automatic t_reset_R8;
        rst = 1'b1; btn_n = 1'b1;
        wait_cycles(4);
        check("R8 press after reset", press, 0);
        check("R8 held after reset", held, 0);
        rst = 1'b0;
        wait_cycles(2);
    endtask

    task automatic t_idle_R1;
        int s0 = strobes;
        high_for(30 * CPT);
        check("R1 idle high gives no strobe", strobes - s0, 0);
        low_for(1); high_for(GAP_OK);
        check("R1 single-cycle low gives no strobe", strobes - s0, 0);
    endtask

    task automatic t_chatter_R2;
        int s0 = strobes;
        for (int k = 0; k < 12; k++) begin
            low_for(3 + k * 5); high_for(2 + (k % 3));
        end
        high_for(GAP_OK);
        check("R2 chatter train gives no strobe", strobes - s0, 0);
        check("R2 held after chatter", held, 0);
        low_for(9 * CPT); high_for(GAP_OK);
        check("R2 nine-tick low rejected", strobes - s0, 0);
        low_for((ACC - 2) * CPT); high_for(2); low_for((ACC - 2) * CPT); high_for(GAP_OK);
        check("R2 timer restarts after bounce", strobes - s0, 0);
    endtask

    task automatic t_press_R3_R4_R5_R6;
        int s0 = strobes;
        int fall;
        first_strobe_cyc = -1;
        fall = cyc;
        low_for((ACC + 2) * CPT);
        check("R3 one strobe on plateau", strobes - s0, 1);
        check("R3 held set", held, 1);
        check("R4 latency not early", (first_strobe_cyc - fall) >= (ACC - 1) * CPT, 1);
        check("R4 latency not late", (first_strobe_cyc - fall) <= ACC * CPT + SYN + 4, 1);
        low_for(40 * CPT);
        check("R5 no second strobe on long hold", strobes - s0, 1);
        check("R5 held stays", held, 1);
        high_for(2);
        low_for(4 * CPT);
        check("R6 short release gap gives no strobe", strobes - s0, 1);
        check("R6 held back after short gap", held, 1);
        high_for(SYN + 2);
        check("R6 held drops after release", held, 0);
        high_for(GAP_OK);
    endtask

    task automatic t_repeat_R7;
        int s0 = strobes;
        for (int k = 0; k < 5; k++) begin
            low_for((ACC + 1) * CPT + SYN + 3);
            high_for(GAP_OK);
        end
        check("R7 repeated presses each counted", strobes - s0, 5);
    endtask

    task automatic t_bounce_then_settle_R3;
        int s0 = strobes;
        for (int k = 0; k < 6; k++) begin low_for(4); high_for(3); end
        low_for((ACC + 2) * CPT);
        check("R3 bounce then settle gives one strobe", strobes - s0, 1);
        high_for(GAP_OK);
    endtask

    task automatic t_reset_midpress_R8;
        low_for((ACC + 2) * CPT);
        rst = 1'b1; wait_cycles(2);
        check("R8 held cleared mid-press", held, 0);
        check("R8 press cleared mid-press", press, 0);
        rst = 1'b0; btn_n = 1'b1; wait_cycles(GAP_OK);
    endtask

    initial begin
        rst = 1'b1; btn_n = 1'b1;
        wait_cycles(1);
        t_reset_R8();
        t_idle_R1();
        t_chatter_R2();
        t_press_R3_R4_R5_R6();
        t_repeat_R7();
        t_bounce_then_settle_R3();
        t_reset_midpress_R8();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(150000 * 20);
        vectors++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule